// File: doc/BRIEF.md
# I2C Target Read-Path Controller with Transmit Queue

This block is the read-direction half of an I2C target. It watches the bus lines for a START condition and an address frame. When it sees its own 7-bit address with the read bit set, it acknowledges and then shifts bytes out of an eight-entry transmit queue. It keeps sending for as long as the remote controller acknowledges and the queue has data, so software can load a whole packet ahead of time. No interrupt is needed between bytes.

When the queue is empty at a byte boundary, the block holds SCL low and raises a read-request flag. It releases SCL as soon as software writes a byte. A NACK in the acknowledge slot ends the transfer. The serial engine then toggles a flush request across into the bus clock domain. There, any unsent bytes are discarded and, if some were left over, a transmit-abort flag is set.

The queue write port and the status flags are in the bus clock domain. The serial engine runs on its own oversampling clock. The queue crosses between the two domains with Gray-coded pointers.

Top module: `i2ct_target_tx`

## Requirements
- R1: The block acknowledges (pulls SDA low in the ninth bit) only an address frame whose upper seven bits equal `TGT_ADDR` and whose eighth bit is 1. Any other frame gets no acknowledge.
- R2: Data bytes are sent MSB first, and `sda_oe` changes only while the SCL line is low.
- R3: While the remote controller acknowledges and the queue holds data, consecutive bytes are sent back to back, with no read request and no SCL stretching.
- R4: When a byte slot opens with the queue empty (right after the address, or after an acknowledged byte), raw status bit 5 is set and SCL is held low. SCL is released once a byte is written, and that byte is the one sent next.
- R5: Raw status bit 5 stays set until a `clr_rd_req` pulse clears it.
- R6: `int_status` equals `raw_status` ANDed with `int_mask`, and `irq` is the OR of `int_status`. With mask bit 5 at 0, a pending read request does not raise `irq`.
- R7: A NACK with bytes still queued empties the queue in the bus domain and sets raw status bit 6. That bit is cleared by `clr_tx_abort`.
- R8: A NACK with the queue empty ends the transfer without setting raw status bit 6.
- R9: The queue holds 8 bytes. `fifo_full` is 1 after 8 unread writes, and a write while full is dropped.
- R10: During the acknowledge slot after each data byte, the block releases SDA so that the remote controller's ACK or NACK can be seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus-side clock |
| bus_rst_n | input | 1 | Bus-side active-low reset |
| wr_en | input | 1 | Queue write strobe |
| wr_data | input | 8 | Byte to queue |
| fifo_full | output | 1 | Queue holds 8 unread bytes |
| int_mask | input | 8 | Interrupt enable per status bit |
| clr_rd_req | input | 1 | Clears raw status bit 5 |
| clr_tx_abort | input | 1 | Clears raw status bit 6 |
| raw_status | output | 8 | Bit 5 read request, bit 6 transmit abort, other bits 0 |
| int_status | output | 8 | Masked status |
| irq | output | 1 | OR of masked status |
| ser_clk | input | 1 | Serial engine oversampling clock |
| ser_rst_n | input | 1 | Serial-side active-low reset |
| scl_in | input | 1 | Sampled SCL line |
| sda_in | input | 1 | Sampled SDA line |
| scl_oe | output | 1 | 1 pulls SCL low (stretch) |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The bench uses the default parameters: an 8-entry queue and target address 0x2A. With these values a burst of nine writes is enough to reach the full condition and the dropped write. The serial clock is faster than the bus clock and not related to it, and each SCL phase lasts many cycles of either clock. This lets the bench reach the stretch-then-release case and the flush after a NACK, and compare every status bit on every bus clock.

// File: rtl/i2ct_pkg.sv
`timescale 1ns/1ps
package i2ct_pkg;
  localparam int BYTE_W    = 8;
  localparam int RDREQ_BIT = 5;
  localparam int ABORT_BIT = 6;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_LOAD, ST_SEND, ST_RACK
  } eng_state_t;

  // address frame selects this target for a read
  function automatic logic read_hit(input logic [BYTE_W-1:0] frame,
                                    input logic [6:0] own);
    return (frame[BYTE_W-1:1] == own) && frame[0];
  endfunction
endpackage

// File: rtl/i2ct_toggle_sync.sv
`timescale 1ns/1ps
module i2ct_toggle_sync (
  input  logic src_clk,
  input  logic src_rst_n,
  input  logic src_pulse,
  input  logic dst_clk,
  input  logic dst_rst_n,
  output logic dst_pulse
);
  logic       src_tgl;
  logic [2:0] dst_q;

  always_ff @(posedge src_clk or negedge src_rst_n)
    if (!src_rst_n)     src_tgl <= 1'b0;
    else if (src_pulse) src_tgl <= ~src_tgl;

  always_ff @(posedge dst_clk or negedge dst_rst_n)
    if (!dst_rst_n) dst_q <= '0;
    else            dst_q <= {dst_q[1:0], src_tgl};

  assign dst_pulse = dst_q[2] ^ dst_q[1];
endmodule

// File: rtl/i2ct_tx_fifo.sv
`timescale 1ns/1ps
module i2ct_tx_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 8
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          flush,
  output logic          full,
  output logic [$clog2(DEPTH):0] level,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wbin, wbin_nxt, wgray, rgray_s1, rgray_s2, rbin_w;
  logic [PW-1:0] rbin, rbin_nxt, rgray, wgray_s1, wgray_s2;
  logic          do_write;

  // write (bus) side
  assign rbin_w   = from_gray(rgray_s2);
  assign level    = wbin - rbin_w;
  assign full     = (level == PW'(DEPTH));
  assign do_write = wr_en && !full && !flush;
  assign wbin_nxt = flush ? rbin_w : (do_write ? wbin + 1'b1 : wbin);

  always_ff @(posedge wclk or negedge wrst_n)
    if (!wrst_n) begin
      wbin <= '0; wgray <= '0; rgray_s1 <= '0; rgray_s2 <= '0;
    end else begin
      wbin     <= wbin_nxt;
      wgray    <= to_gray(wbin_nxt);
      rgray_s1 <= rgray;
      rgray_s2 <= rgray_s1;
    end

  always_ff @(posedge wclk)
    if (do_write) mem[wbin[AW-1:0]] <= wr_data;

  // read (serial) side
  assign empty    = (rgray == wgray_s2);
  assign rd_data  = mem[rbin[AW-1:0]];
  assign rbin_nxt = (rd_en && !empty) ? rbin + 1'b1 : rbin;

  always_ff @(posedge rclk or negedge rrst_n)
    if (!rrst_n) begin
      rbin <= '0; rgray <= '0; wgray_s1 <= '0; wgray_s2 <= '0;
    end else begin
      rbin     <= rbin_nxt;
      rgray    <= to_gray(rbin_nxt);
      wgray_s1 <= wgray;
      wgray_s2 <= wgray_s1;
    end
endmodule

// File: rtl/i2ct_serial_engine.sv
`timescale 1ns/1ps
module i2ct_serial_engine import i2ct_pkg::*; #(
  parameter logic [6:0] TGT_ADDR = 7'h2A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              fifo_empty,
  input  logic [BYTE_W-1:0] fifo_data,
  output logic              fifo_pop,
  output logic              sda_oe,
  output logic              scl_oe,
  output logic              rdreq_evt,
  output logic              nack_evt,
  output logic              in_ack_slot
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  eng_state_t        state;
  logic [2:0]        scl_q, sda_q;
  logic [BYTE_W-1:0] sh;
  logic [CNT_W-1:0]  cnt;
  logic              req_sent, nack_q;
  logic              scl_rise, scl_fall, start_det, stop_det;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 3'b111; sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_in};
      sda_q <= {sda_q[1:0], sda_in};
    end

  assign scl_rise  = scl_q[1] & ~scl_q[2];
  assign scl_fall  = ~scl_q[1] & scl_q[2];
  assign start_det = scl_q[1] & scl_q[2] & ~sda_q[1] & sda_q[2];
  assign stop_det  = scl_q[1] & scl_q[2] & sda_q[1] & ~sda_q[2];

  assign fifo_pop    = (state == ST_LOAD) && !fifo_empty;
  assign rdreq_evt   = (state == ST_LOAD) && fifo_empty && !req_sent;
  assign nack_evt    = (state == ST_RACK) && scl_fall && nack_q;
  assign in_ack_slot = (state == ST_RACK);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= ST_IDLE; sh <= '0; cnt <= '0;
      req_sent <= 1'b0; nack_q <= 1'b0; sda_oe <= 1'b0; scl_oe <= 1'b0;
    end else if (start_det) begin
      state <= ST_ADDR; cnt <= '0; sda_oe <= 1'b0; scl_oe <= 1'b0;
    end else if (stop_det) begin
      state <= ST_IDLE; sda_oe <= 1'b0; scl_oe <= 1'b0;
    end else begin
      case (state)
        ST_ADDR: begin
          if (scl_rise) begin
            sh  <= {sh[BYTE_W-2:0], sda_q[1]};
            cnt <= cnt + 1'b1;
          end else if (scl_fall && cnt == CNT_W'(BYTE_W)) begin
            if (read_hit(sh, TGT_ADDR)) begin
              state <= ST_AACK; sda_oe <= 1'b1;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_AACK: if (scl_fall) begin
          sda_oe <= 1'b0; state <= ST_LOAD; req_sent <= 1'b0;
        end
        ST_LOAD: begin
          if (fifo_empty) begin
            scl_oe <= 1'b1; req_sent <= 1'b1;
          end else begin
            sh     <= fifo_data;
            sda_oe <= ~fifo_data[BYTE_W-1];
            scl_oe <= 1'b0;
            cnt    <= '0;
            state  <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (scl_rise) cnt <= cnt + 1'b1;
          else if (scl_fall) begin
            if (cnt == CNT_W'(BYTE_W)) begin
              sda_oe <= 1'b0; state <= ST_RACK;
            end else begin
              sh     <= {sh[BYTE_W-2:0], 1'b0};
              sda_oe <= ~sh[BYTE_W-2];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) nack_q <= sda_q[1];
          else if (scl_fall) begin
            if (nack_q) state <= ST_IDLE;
            else begin
              state <= ST_LOAD; req_sent <= 1'b0;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
endmodule

// File: rtl/i2ct_target_tx.sv
`timescale 1ns/1ps
module i2ct_target_tx import i2ct_pkg::*; #(
  parameter int         DEPTH    = 8,
  parameter logic [6:0] TGT_ADDR = 7'h2A
) (
  input  logic              bus_clk,
  input  logic              bus_rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              fifo_full,
  input  logic [7:0]        int_mask,
  input  logic              clr_rd_req,
  input  logic              clr_tx_abort,
  output logic [7:0]        raw_status,
  output logic [7:0]        int_status,
  output logic              irq,
  input  logic              ser_clk,
  input  logic              ser_rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe
);
  localparam int PW = $clog2(DEPTH) + 1;

  // named internal events, also seen by the checker
  logic              fifo_empty_ser, fifo_pop, rdreq_evt, nack_evt, in_ack_slot;
  logic              rdreq_bus, flush_bus;
  logic [PW-1:0]     fifo_level;
  logic [BYTE_W-1:0] fifo_q;
  logic              rd_req_q, abort_q;

  i2ct_tx_fifo #(.DW(BYTE_W), .DEPTH(DEPTH)) u_fifo (
    .wclk(bus_clk), .wrst_n(bus_rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .flush(flush_bus), .full(fifo_full), .level(fifo_level),
    .rclk(ser_clk), .rrst_n(ser_rst_n), .rd_en(fifo_pop), .rd_data(fifo_q),
    .empty(fifo_empty_ser)
  );

  i2ct_serial_engine #(.TGT_ADDR(TGT_ADDR)) u_eng (
    .clk(ser_clk), .rst_n(ser_rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .fifo_empty(fifo_empty_ser), .fifo_data(fifo_q), .fifo_pop(fifo_pop),
    .sda_oe(sda_oe), .scl_oe(scl_oe), .rdreq_evt(rdreq_evt),
    .nack_evt(nack_evt), .in_ack_slot(in_ack_slot)
  );

  i2ct_toggle_sync u_rdreq_x (
    .src_clk(ser_clk), .src_rst_n(ser_rst_n), .src_pulse(rdreq_evt),
    .dst_clk(bus_clk), .dst_rst_n(bus_rst_n), .dst_pulse(rdreq_bus)
  );

  i2ct_toggle_sync u_flush_x (
    .src_clk(ser_clk), .src_rst_n(ser_rst_n), .src_pulse(nack_evt),
    .dst_clk(bus_clk), .dst_rst_n(bus_rst_n), .dst_pulse(flush_bus)
  );

  // sticky flags; a new event wins over a clear in the same cycle
  always_ff @(posedge bus_clk or negedge bus_rst_n)
    if (!bus_rst_n) begin
      rd_req_q <= 1'b0; abort_q <= 1'b0;
    end else begin
      if (rdreq_bus)       rd_req_q <= 1'b1;
      else if (clr_rd_req) rd_req_q <= 1'b0;
      if (flush_bus && fifo_level != '0) abort_q <= 1'b1;
      else if (clr_tx_abort)             abort_q <= 1'b0;
    end

  always_comb begin
    raw_status            = '0;
    raw_status[RDREQ_BIT] = rd_req_q;
    raw_status[ABORT_BIT] = abort_q;
  end

  assign int_status = raw_status & int_mask;
  assign irq        = |int_status;
endmodule

// File: rtl/i2ct_target_tx_chk.sv
`timescale 1ns/1ps
module i2ct_target_tx_chk #(
  parameter int DEPTH = 8
) (
  input logic                    bus_clk,
  input logic                    bus_rst_n,
  input logic                    ser_clk,
  input logic                    ser_rst_n,
  input logic                    scl_in,
  input logic                    sda_oe,
  input logic                    scl_oe,
  input logic [7:0]              raw_status,
  input logic                    clr_rd_req,
  input logic [$clog2(DEPTH):0]  fifo_level,
  input logic                    flush_bus,
  input logic                    fifo_empty_ser,
  input logic                    in_ack_slot
);
  // R2: SDA drive never moves while SCL is high
  p_sda_quiet_high_r2: assert property (@(posedge ser_clk) disable iff (!ser_rst_n)
    scl_in && $past(scl_in) |-> $stable(sda_oe));

  // R4: stretch ends once the queue has data
  p_stretch_release_r4: assert property (@(posedge ser_clk) disable iff (!ser_rst_n)
    scl_oe && !fifo_empty_ser |=> !scl_oe);

  // R5: read request is sticky
  p_rdreq_sticky_r5: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    raw_status[5] && !clr_rd_req |=> raw_status[5]);

  // R7: flush empties the queue
  p_flush_empties_r7: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    flush_bus |=> fifo_level == '0);

  // R9: fill level never exceeds depth
  p_no_overflow_r9: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    fifo_level <= ($clog2(DEPTH)+1)'(DEPTH));

  // R10: SDA released in the acknowledge slot
  p_ack_slot_free_r10: assert property (@(posedge ser_clk) disable iff (!ser_rst_n)
    in_ack_slot |-> !sda_oe);
endmodule

bind i2ct_target_tx i2ct_target_tx_chk #(.DEPTH(DEPTH)) u_chk (
  .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .ser_clk(ser_clk),
  .ser_rst_n(ser_rst_n), .scl_in(scl_in), .sda_oe(sda_oe), .scl_oe(scl_oe),
  .raw_status(raw_status), .clr_rd_req(clr_rd_req), .fifo_level(fifo_level),
  .flush_bus(flush_bus), .fifo_empty_ser(fifo_empty_ser),
  .in_ack_slot(in_ack_slot)
);

// File: tb/i2ct_target_tx_test.sv
`timescale 1ns/1ps
module i2ct_target_tx_test;
  localparam time TQ = 250ns;

  logic bus_clk = 0, ser_clk = 0, bus_rst_n = 0, ser_rst_n = 0;
  logic wr_en = 0, clr_rd_req = 0, clr_tx_abort = 0;
  logic [7:0] wr_data = 0, int_mask = 0;
  logic fifo_full, irq, scl_oe, sda_oe;
  logic [7:0] raw_status, int_status;
  logic m_scl_low = 0, m_sda_low = 0;
  wire  scl_line = !(m_scl_low || scl_oe);
  wire  sda_line = !(m_sda_low || sda_oe);

  int tests = 0, fails = 0;
  bit done = 0, saw_stretch = 0;
  byte q[$];

  always #10ns bus_clk = ~bus_clk;
  always #7ns  ser_clk = ~ser_clk;

  i2ct_target_tx uut (
    .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .fifo_full(fifo_full), .int_mask(int_mask), .clr_rd_req(clr_rd_req),
    .clr_tx_abort(clr_tx_abort), .raw_status(raw_status),
    .int_status(int_status), .irq(irq), .ser_clk(ser_clk),
    .ser_rst_n(ser_rst_n), .scl_in(scl_line), .sda_in(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R6 compared on every bus clock
  always @(negedge bus_clk)
    if (bus_rst_n && !done) begin
      chk(int_status == (raw_status & int_mask), "R6 int_status", int_status, raw_status & int_mask);
      chk(irq == (|(raw_status & int_mask)), "R6 irq", irq, |(raw_status & int_mask));
    end

  always @(negedge bus_clk) if (scl_oe) saw_stretch = 1;

  task automatic bus_write(input byte d);
    @(negedge bus_clk);
    if (q.size() < 8) q.push_back(d);
    wr_en = 1; wr_data = d;
    @(negedge bus_clk);
    wr_en = 0;
  endtask

  task automatic m_start();
    m_sda_low = 0; m_scl_low = 0; #TQ;
    m_sda_low = 1; #TQ; m_scl_low = 1; #TQ;
  endtask

  task automatic m_stop();
    m_sda_low = 1; #TQ; m_scl_low = 0; wait (scl_line === 1'b1); #TQ;
    m_sda_low = 0; #(2*TQ);
  endtask

  task automatic m_send_bit(input bit b);
    m_sda_low = !b; #TQ; m_scl_low = 0; wait (scl_line === 1'b1);
    #(2*TQ); m_scl_low = 1; #TQ;
  endtask

  task automatic m_recv_bit(output bit b);
    m_sda_low = 0; #TQ; m_scl_low = 0; wait (scl_line === 1'b1);
    #TQ; b = sda_line; #TQ; m_scl_low = 1; #TQ;
  endtask

  task automatic m_addr(input logic [6:0] a, input bit rw, output bit acked);
    bit b;
    for (int i = 6; i >= 0; i--) m_send_bit(a[i]);
    m_send_bit(rw);
    m_recv_bit(b);
    acked = !b;
  endtask

  task automatic m_read_byte(input bit ack, output byte d, output bit released);
    bit b;
    d = 0;
    for (int i = 0; i < 8; i++) begin m_recv_bit(b); d = {d[6:0], b}; end
    m_sda_low = ack; #TQ; m_scl_low = 0; wait (scl_line === 1'b1);
    #TQ; released = !sda_oe; #TQ; m_scl_low = 1; #TQ; m_sda_low = 0;
  endtask

  // read n bytes, NACK the last, compare against the model queue
  task automatic read_burst(input int n, input string req);
    byte d, e; bit rel, ok; bit left;
    m_start(); m_addr(7'h2A, 1, ok);
    chk(ok, "R1 address ack", ok, 1);
    for (int i = 0; i < n; i++) begin
      m_read_byte(i != n-1, d, rel);
      e = q.pop_front();
      chk(d == e, req, d, e);
      chk(rel, "R10 ack slot released", rel, 1);
    end
    left = (q.size() != 0);
    q.delete();
    m_stop();
    repeat (20) @(negedge bus_clk);
    chk(raw_status[6] == left, left ? "R7 abort set" : "R8 no abort", raw_status[6], left);
  endtask

  task automatic pulse_clear(input bit rd, input bit ab);
    @(negedge bus_clk); clr_rd_req = rd; clr_tx_abort = ab;
    @(negedge bus_clk); clr_rd_req = 0; clr_tx_abort = 0;
  endtask

  initial begin
    #3ms;
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    byte d; bit rel, ok;
    repeat (10) @(negedge bus_clk);
    bus_rst_n = 1; ser_rst_n = 1;
    repeat (5) @(negedge bus_clk);
    chk(raw_status == 0 && !irq && !sda_oe && !scl_oe && !fifo_full, "R9 reset state", raw_status, 0);

    // R9: fill to depth, one extra write dropped
    for (int i = 0; i < 8; i++) bus_write(8'h10 + 8'(i));
    @(negedge bus_clk);
    chk(fifo_full, "R9 full after 8", fifo_full, 1);
    bus_write(8'hEE);
    // R3/R2/R8: stream all 8, NACK the last with queue empty
    saw_stretch = 0;
    read_burst(8, "R3 streamed byte");
    chk(!saw_stretch, "R3 no stretch", saw_stretch, 0);
    chk(!raw_status[5], "R3 no read request", raw_status[5], 0);

    // R7: leftovers discarded
    for (int i = 0; i < 5; i++) bus_write(8'hA0 + 8'(i));
    read_burst(2, "R2 msb-first byte");
    chk(!fifo_full, "R7 queue not full", fifo_full, 0);
    pulse_clear(0, 1);
    chk(!raw_status[6], "R7 abort cleared", raw_status[6], 0);

    // R4/R5/R6: empty queue, stretch, service
    int_mask = 8'h00;
    m_start(); m_addr(7'h2A, 1, ok);
    chk(ok, "R1 address ack", ok, 1);
    fork
      m_read_byte(1, d, rel);
      begin
        for (int i = 0; i < 2000 && !raw_status[5]; i++) @(negedge bus_clk);
        chk(raw_status[5], "R4 read request (queue was flushed)", raw_status[5], 1);
        chk(scl_oe, "R4 scl stretched", scl_oe, 1);
        chk(!irq, "R6 masked irq low", irq, 0);
        int_mask = 8'h60;
        @(negedge bus_clk);
        chk(irq && int_status[5], "R6 irq with mask", irq, 1);
        bus_write(8'h5C);
        repeat (10) @(negedge bus_clk);
        chk(!scl_oe, "R4 stretch released", scl_oe, 0);
        chk(raw_status[5], "R5 still set", raw_status[5], 1);
        pulse_clear(1, 0);
        chk(!raw_status[5], "R5 cleared", raw_status[5], 0);
      end
    join
    chk(d == q.pop_front() || d == 8'h5C, "R4 serviced byte", d, 8'h5C);
    chk(d == 8'h5C, "R4 serviced byte value", d, 8'h5C);
    fork
      m_read_byte(0, d, rel);
      begin
        for (int i = 0; i < 2000 && !raw_status[5]; i++) @(negedge bus_clk);
        chk(raw_status[5], "R4 raised again after ack", raw_status[5], 1);
        bus_write(8'h77);
      end
    join
    chk(d == 8'h77, "R4 second byte", d, 8'h77);
    void'(q.pop_front());
    m_stop();
    repeat (20) @(negedge bus_clk);
    chk(!raw_status[6], "R8 no abort on empty nack", raw_status[6], 0);
    pulse_clear(1, 0);

    // R1: wrong address, write bit
    m_start(); m_addr(7'h33, 1, ok); m_stop();
    chk(!ok, "R1 wrong address", ok, 0);
    m_start(); m_addr(7'h2A, 0, ok); m_stop();
    chk(!ok, "R1 write direction", ok, 0);
    repeat (20) @(negedge bus_clk);
    chk(raw_status == 0, "R1 no request raised", raw_status, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule